// File: doc/BRIEF.md
# Multiplexed Display Scan Generator

This block drives the time-multiplexed scan of an eight-position, sixteen-segment-plus-point character display. A free-running prescaler divides the base clock by 64. Each time the prescaler wraps, a 3-bit position counter moves on to the next character. The position counter is used in two ways. It is the read address into an external display memory. It is also decoded into one-hot, active-high character enables.

The 6-bit code returned by the memory goes through a font lookup that produces 17 segment lines. The character enables and the segment lines are registered together, so both change on the same clock edge. A one-cycle dark gap is inserted at the end of every slot to prevent ghosting.

All outputs go dark while the surrounding logic reports a qualifying write in progress. A shutdown input clears the divider chain, darkens the display and drops a driver output-enable. The pad logic uses that enable to release the lines.

Top module: `disp_scan_gen`

## Requirements
- R1: The prescaler counts 0 to 63 on every clock edge, one step per edge. The position counter advances by one, wrapping 7 to 0, only on the edge where the prescaler wraps from 63 to 0. Each slot therefore lasts 64 cycles and a full scan lasts 512 cycles.
- R2: `mem_addr` always equals the current position counter value.
- R3: `char_en` is registered and active high. It has at most one bit set. After an edge, bit i is set when the position counter held i before that edge; bit 0 is the leftmost character. `seg` is taken from the code present before that same edge.
- R4: After each edge at which the prescaler held 63, `char_en` and `seg` are all zero for one cycle.
- R5: The font maps code 6'b100000 to all segments off. Any other code c maps to `seg` = {c, ~c, c[4:0] ^ c[5:1]}. In this concatenation bits 16:11 hold c, bits 10:5 hold ~c, and bits 4:0 hold the XOR term.
- R6: When `wr_active` is high at an edge, `char_en` and `seg` are zero after that edge. The prescaler and position counter keep running during writes.
- R7: When `shutdown` is high at an edge, the edge clears the prescaler and position counter, zeroes `char_en` and `seg`, and drives `drv_oe` low. After `shutdown` is released, the scan restarts at character 1 with `drv_oe` high.
- R8: While `rst_n` is low, `char_en`, `seg`, `drv_oe` and `mem_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base scan clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shutdown | input | 1 | Low-power request: clears the divider chain and releases the drivers |
| wr_active | input | 1 | A qualifying write is in progress |
| mem_code | input | 6 | Character code read from display memory at `mem_addr` |
| mem_addr | output | 3 | Display memory read address (position counter) |
| char_en | output | 8 | One-hot character enables, active high |
| seg | output | 17 | Segment lines, bit 16 down to 0 |
| drv_oe | output | 1 | Output-enable for the display drivers |

## Verification
The scan is run over a memory holding eight distinct codes, including the blank code. A run with distinct codes exposes any mix-up between position and address, and the blank code separates the dedicated font entry from the computed ones. The memory is then rewritten while the scan runs, to show that segments follow the code present at each slot rather than a stale value. Write pulses of different lengths fall both inside slots and across a slot boundary. These show that writes darken the outputs without stopping the counters. Shutdown is applied mid-slot and held for several cycles. The restart must then begin at character 1 with a full-length first slot, which distinguishes a true clear from a mere pause.

// File: rtl/disp_scan_gen.sv
module disp_scan_gen #(
  parameter int NUM_CHARS = 8,
  parameter int PRE_DIV   = 64,
  parameter int CODE_W    = 6,
  parameter int SEG_W     = 17
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shutdown,
  input  logic                          wr_active,
  input  logic [CODE_W-1:0]             mem_code,
  output logic [$clog2(NUM_CHARS)-1:0]  mem_addr,
  output logic [NUM_CHARS-1:0]          char_en,
  output logic [SEG_W-1:0]              seg,
  output logic                          drv_oe
);

  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int POS_W = $clog2(NUM_CHARS);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(NUM_CHARS - 1);
  localparam logic [CODE_W-1:0] BLANK_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [PRE_W-1:0]     pre_q;
  logic [POS_W-1:0]     pos_q;
  logic [NUM_CHARS-1:0] char_en_q, char_nx;
  logic [SEG_W-1:0]     seg_q;
  logic                 oe_q;

  wire gap  = (pre_q == PRE_LAST);
  wire dark = gap | wr_active | shutdown;

  function automatic logic [SEG_W-1:0] font(input logic [CODE_W-1:0] c);
    logic [SEG_W-1:0] f;
    case (c)
      BLANK_CODE: f = '0;
      default:    f = SEG_W'({c, ~c, c[CODE_W-2:0] ^ c[CODE_W-1:1]});
    endcase
    return f;
  endfunction

  always_comb begin
    char_nx = '0;
    char_nx[pos_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      pos_q <= '0;
    end else if (shutdown) begin
      pre_q <= '0;
      pos_q <= '0;
    end else begin
      pre_q <= gap ? '0 : pre_q + 1'b1;
      if (gap) pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_en_q <= '0;
      seg_q     <= '0;
      oe_q      <= 1'b0;
    end else begin
      char_en_q <= dark ? '0 : char_nx;
      seg_q     <= dark ? '0 : font(mem_code);
      oe_q      <= !shutdown;
    end
  end

  assign mem_addr = pos_q;
  assign char_en  = char_en_q;
  assign seg      = seg_q;
  assign drv_oe   = oe_q;

  AST_ONE_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(char_en)); // R3
  AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    gap |=> (char_en == '0 && seg == '0)); // R4
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gap && !shutdown) |=> pos_q == POS_W'($past(pos_q) + 1'b1)); // R1
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!gap && !shutdown) |=> $stable(pos_q)); // R1
  AST_WR_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active |=> (char_en == '0 && seg == '0)); // R6
  AST_SHDN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (pre_q == '0 && pos_q == '0 && char_en == '0 && !drv_oe)); // R7

endmodule

// File: tb/disp_scan_gen_tb.sv
module disp_scan_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shutdown = 1'b0;
  logic wr_active = 1'b0;
  logic [5:0] mem [8];
  logic [5:0] mem_code;
  logic [2:0] mem_addr;
  logic [7:0] char_en;
  logic [16:0] seg;
  logic drv_oe;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0]  ch;
    logic [16:0] sg;
    logic        oe;
    logic [2:0]  addr;
    string       tag;
  } item_t;
  item_t q[$];

  logic [5:0] m_pre;
  logic [2:0] m_pos;

  always #2.5 clk = ~clk;

  assign mem_code = mem[mem_addr];

  disp_scan_gen dut_i (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .wr_active(wr_active),
    .mem_code(mem_code), .mem_addr(mem_addr), .char_en(char_en),
    .seg(seg), .drv_oe(drv_oe)
  );

  function automatic logic [16:0] ref_font(input logic [5:0] c);
    if (c == 6'b100000) return '0;   // R5 blank entry
    return {c, ~c, c[4:0] ^ c[5:1]};
  endfunction

  // reference model / driver side: push expectation for each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = '0;
      m_pos = '0;
    end else begin
      item_t it;
      if (shutdown) begin
        it.ch = '0; it.sg = '0; it.oe = 1'b0; it.tag = "R7";
        m_pre = '0;
        m_pos = '0;
      end else begin
        it.oe = 1'b1;
        if (m_pre == 6'd63) begin
          it.ch = '0; it.sg = '0; it.tag = "R4";
        end else if (wr_active) begin
          it.ch = '0; it.sg = '0; it.tag = "R6";
        end else begin
          it.ch = 8'b1 << m_pos;
          it.sg = ref_font(mem[m_pos]);
          it.tag = (mem[m_pos] == 6'b100000) ? "R5" : "R1/R3/R5";
        end
        if (m_pre == 6'd63) m_pos = m_pos + 3'd1;
        m_pre = m_pre + 6'd1;
      end
      it.addr = m_pos;
      q.push_back(it);
    end
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (char_en !== it.ch || seg !== it.sg || drv_oe !== it.oe) begin
        errors++;
        $display("FAIL %s: char_en=%b seg=%h oe=%b expected char_en=%b seg=%h oe=%b",
                 it.tag, char_en, seg, drv_oe, it.ch, it.sg, it.oe);
      end
      checks++;
      if (mem_addr !== it.addr) begin
        errors++;
        $display("FAIL R2: mem_addr=%0d expected %0d", mem_addr, it.addr);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_pulse(input int len);
    @(negedge clk);
    wr_active = 1'b1;
    idle(len);
    wr_active = 1'b0;
  endtask

  initial begin
    bit done = 0;
    for (int i = 0; i < 8; i++) mem[i] = 6'(i * 7 + 3);
    mem[5] = 6'b100000;
    fork
      begin
        idle(3);
        // R8 reset state
        checks++;
        if (char_en !== '0 || seg !== '0 || drv_oe !== 1'b0 || mem_addr !== '0) begin
          errors++;
          $display("FAIL R8: char_en=%b seg=%h oe=%b addr=%0d expected all zero",
                   char_en, seg, drv_oe, mem_addr);
        end
        rst_n = 1'b1;
        idle(1100);                       // R1 R3 R4 R5: two full scans
        for (int i = 0; i < 8; i++) mem[i] = 6'(63 - i * 5);
        idle(600);
        write_pulse(4);                   // R6 inside a slot
        idle(20);
        idle(PRE_PAD());
        write_pulse(70);                  // R6 across a slot boundary
        idle(100);
        shutdown = 1'b1;                  // R7 mid-slot
        idle(9);
        shutdown = 1'b0;
        idle(600);
        idle(2);
        done = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog: run did not complete, expected completion");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int PRE_PAD();
    return 37;
  endfunction

endmodule